// File: doc/BRIEF.md
# Console Buffer Transfer Engine

This block performs the two bulk data moves of a console peripheral. Software loads a 64-bit memory pointer from two 32-bit writes and a 32-bit byte count from a third write. It then issues a command. A transmit command fetches that many bytes from memory, starting at the pointer and moving upward, and emits them one by one on a character output stream. A receive command takes the oldest bytes out of an internal receive queue, stores them at ascending addresses from the pointer, and removes them from the queue.

Incoming characters enter the receive queue through a valid/ready stream. The memory side is a single-byte request/acknowledge master. An interrupt line is high whenever interrupts are enabled and the queue holds data. A receive command that asks for more bytes than the queue holds is refused: it raises an error flag and moves nothing.

Top module: `con_xfer_engine`

## Requirements
- R1: A configuration write with `cfg_sel`=0 replaces pointer bits 31:0. A write with `cfg_sel`=1 replaces bits 63:32. The next accepted transfer starts its first memory access at the resulting pointer, and the address increases by one per acknowledged byte, with carry into the upper word.
- R2: When `sext_mode` is high during a `cfg_sel`=0 write, pointer bits 63:32 become copies of bit 31 of the written word.
- R3: A transmit command (`cmd_op`=0) with a programmed length of N issues N read accesses (`mem_we`=0) at ascending addresses. The cycle after each acknowledge, `tx_valid` pulses for one cycle with `tx_data` equal to the byte returned.
- R4: A receive command (`cmd_op`=1) writes (`mem_we`=1) the N oldest queued bytes to ascending addresses, oldest first. Each acknowledge removes one byte. The remaining bytes keep their order, and `rx_count` drops by N overall.
- R5: A receive command whose length (`cfg_sel`=2 write) exceeds `rx_count` sets `err`, starts no memory access and leaves the queue unchanged. Any later accepted command clears `err` before it runs.
- R6: `busy` is high from the cycle after a transfer is accepted until the cycle after its last acknowledge. A command presented while `busy` is high is ignored.
- R7: A command with length 0 completes at once: `busy` stays low, no memory request is made and `err` is cleared.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and (for writes) `mem_wdata` hold their values into the next cycle.
- R9: `irq` is high exactly when `irq_en` is high and `rx_count` is non-zero. It therefore drops once a receive command empties the queue.
- R10: The receive queue holds up to DEPTH (default 128) bytes. `rx_in_ready` is low when the queue is full, and a byte offered at that time is dropped.
- R11: After reset, `busy`, `err`, `mem_req`, `tx_valid` and `rx_count` are zero, `rx_in_ready` is high, and the pointer and length are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 pointer low word, 1 pointer high word, 2 length |
| cfg_wdata | input | 32 | Configuration write data |
| sext_mode | input | 1 | Sign-extend bit 31 on pointer low-word writes |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 transmit from memory, 1 receive into memory |
| rx_in_valid | input | 1 | Incoming character valid |
| rx_in_data | input | 8 | Incoming character |
| rx_in_ready | output | 1 | Receive queue has space |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Data-available interrupt |
| tx_valid | output | 1 | Outgoing character strobe |
| tx_data | output | 8 | Outgoing character |
| mem_req | output | 1 | Memory byte access request |
| mem_we | output | 1 | 1 write to memory, 0 read |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last command over-read the receive queue |
| rx_count | output | 8 | Bytes held in the receive queue |

## Verification
The bench goes after the pointer's edges. A low word of 0xFFFFFFFE with a non-zero high word makes the byte address carry into bit 32. A design that increments only 32 bits would wrap to zero there. A sign-extended low-word write with bit 31 set would leave the old upper word in place if the mode input were ignored. A receive request one byte larger than the queue must leave the count untouched, and an off-by-one length compare would start a transfer. Further stimulus covers a second command sent mid-transfer, a length of zero, and a fill past 128 bytes followed by a full drain across the wrap of the circular pointers. A design that mishandled these would restart or corrupt a transfer, issue a spurious request, overwrite the oldest byte, or keep the interrupt asserted.

// File: rtl/con_xfer_pkg.sv
`timescale 1ns/1ps
package con_xfer_pkg;
   typedef enum logic [1:0] {
      SEL_PTR_LO = 2'd0,
      SEL_PTR_HI = 2'd1,
      SEL_LEN    = 2'd2
   } cfg_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_TX   = 2'd1,
      ST_RX   = 2'd2
   } xfer_state_e;

   localparam logic OP_TX = 1'b0;
   localparam logic OP_RX = 1'b1;
endpackage

// File: rtl/con_ptr_regs.sv
`timescale 1ns/1ps
module con_ptr_regs
   import con_xfer_pkg::*;
#(
   parameter int REG_W   = 32,
   parameter bit SEXT_EN = 1'b1,
   localparam int PTR_W  = 2 * REG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       sel,
   input  logic [REG_W-1:0] wdata,
   input  logic             sext_mode,
   output logic [PTR_W-1:0] ptr_o,
   output logic [REG_W-1:0] len_o
);
   logic sext_on;

   generate
      if (SEXT_EN) begin : g_sext
         assign sext_on = sext_mode;
      end else begin : g_nosext
         logic unused_sext;
         assign unused_sext = sext_mode;
         assign sext_on     = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_o <= '0;
         len_o <= '0;
      end else if (we) begin
         case (cfg_sel_e'(sel))
            SEL_PTR_LO: begin
               ptr_o[REG_W-1:0] <= wdata;
               if (sext_on) ptr_o[PTR_W-1:REG_W] <= {REG_W{wdata[REG_W-1]}};
            end
            SEL_PTR_HI: ptr_o[PTR_W-1:REG_W] <= wdata;
            SEL_LEN:    len_o <= wdata;
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/con_rx_queue.sv
`timescale 1ns/1ps
module con_rx_queue #(
   parameter int DEPTH  = 128,
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic              ready_o,
   output logic [DATA_W-1:0] head_o,
   output logic [CNT_W-1:0]  count_o
);
   logic [DATA_W-1:0] store [DEPTH];
   logic [IDX_W-1:0]  rd_idx, wr_idx;
   logic              do_push;

   assign ready_o = (count_o != CNT_W'(DEPTH));
   assign do_push = push && ready_o;
   assign head_o  = store[rd_idx];

   always_ff @(posedge clk) begin
      if (do_push) store[wr_idx] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_idx  <= '0;
         wr_idx  <= '0;
         count_o <= '0;
      end else begin
         if (do_push) wr_idx <= wr_idx + 1'b1;
         if (pop)     rd_idx <= rd_idx + 1'b1;
         case ({do_push, pop})
            2'b10:   count_o <= count_o + 1'b1;
            2'b01:   count_o <= count_o - 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/con_xfer_fsm.sv
`timescale 1ns/1ps
module con_xfer_fsm
   import con_xfer_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8,
   localparam int PTR_W = 2 * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_op,
   input  logic [PTR_W-1:0]  ptr,
   input  logic [REG_W-1:0]  len,
   input  logic [CNT_W-1:0]  avail,
   input  logic [DATA_W-1:0] head,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PTR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              pop,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              busy,
   output logic              err
);
   xfer_state_e      state;
   logic [REG_W-1:0] remain;
   logic             accept, over_read, beat;

   assign accept    = cmd_valid && (state == ST_IDLE);
   assign over_read = (cmd_op == OP_RX) && (len > REG_W'(avail));
   assign beat      = (state != ST_IDLE) && mem_ack;

   assign busy      = (state != ST_IDLE);
   assign mem_req   = busy;
   assign mem_we    = (state == ST_RX);
   assign mem_wdata = head;
   assign pop       = beat && (state == ST_RX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mem_addr <= '0;
         remain   <= '0;
         err      <= 1'b0;
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else begin
         tx_valid <= 1'b0;
         if (accept) begin
            if (len == '0) begin
               err <= 1'b0;
            end else if (over_read) begin
               err <= 1'b1;
            end else begin
               err      <= 1'b0;
               state    <= (cmd_op == OP_RX) ? ST_RX : ST_TX;
               mem_addr <= ptr;
               remain   <= len;
            end
         end else if (beat) begin
            mem_addr <= mem_addr + 1'b1;
            remain   <= remain - 1'b1;
            if (remain == REG_W'(1)) state <= ST_IDLE;
            if (state == ST_TX) begin
               tx_valid <= 1'b1;
               tx_data  <= mem_rdata;
            end
         end
      end
   end
endmodule

// File: rtl/con_xfer_engine.sv
`timescale 1ns/1ps
module con_xfer_engine
   import con_xfer_pkg::*;
#(
   parameter int REG_W   = 32,
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 128,
   parameter bit SEXT_EN = 1'b1,
   localparam int PTR_W  = 2 * REG_W,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              sext_mode,
   input  logic              cmd_valid,
   input  logic              cmd_op,
   input  logic              rx_in_valid,
   input  logic [DATA_W-1:0] rx_in_data,
   output logic              rx_in_ready,
   input  logic              irq_en,
   output logic              irq,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PTR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic              busy,
   output logic              err,
   output logic [CNT_W-1:0]  rx_count
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (REG_W < CNT_W) begin : g_bad_regw
         $error("REG_W must cover the queue count");
      end
   endgenerate

   logic [PTR_W-1:0]  ptr_q;
   logic [REG_W-1:0]  len_q;
   logic [DATA_W-1:0] head;
   logic              pop;

   con_ptr_regs #(.REG_W(REG_W), .SEXT_EN(SEXT_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .sext_mode(sext_mode), .ptr_o(ptr_q), .len_o(len_q)
   );

   con_rx_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
      .clk(clk), .rst_n(rst_n), .push(rx_in_valid), .push_data(rx_in_data),
      .pop(pop), .ready_o(rx_in_ready), .head_o(head), .count_o(rx_count)
   );

   con_xfer_fsm #(.REG_W(REG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .ptr(ptr_q), .len(len_q), .avail(rx_count), .head(head),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pop(pop),
      .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy), .err(err)
   );

   assign irq = irq_en && (rx_count != '0);
endmodule

// File: rtl/con_xfer_checker.sv
`timescale 1ns/1ps
module con_xfer_checker #(
   parameter int REG_W  = 32,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 128,
   parameter int PTR_W  = 64,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_op,
   input logic [REG_W-1:0]  len_q,
   input logic              rx_in_valid,
   input logic              rx_in_ready,
   input logic              irq_en,
   input logic              irq,
   input logic              tx_valid,
   input logic              mem_req,
   input logic              mem_we,
   input logic [PTR_W-1:0]  mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic              busy,
   input logic              err,
   input logic [CNT_W-1:0]  rx_count
);
   p_tx_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(mem_req && mem_ack && !mem_we));

   p_rx_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack && !(rx_in_valid && rx_in_ready))
      |=> rx_count == $past(rx_count) - 1'b1);

   p_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && cmd_op && len_q > REG_W'(rx_count))
      |=> err && !busy && !mem_req);

   p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> $stable(err));

   p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && len_q == '0) |=> !busy && !mem_req && !err);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && (!mem_we || $stable(mem_wdata)));

   p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(irq) && irq_en) |-> rx_count == '0);

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CNT_W'(DEPTH));
endmodule

bind con_xfer_engine con_xfer_checker #(
   .REG_W(REG_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .len_q(len_q), .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
   .irq_en(irq_en), .irq(irq), .tx_valid(tx_valid), .mem_req(mem_req),
   .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mem_ack(mem_ack), .busy(busy), .err(err), .rx_count(rx_count)
);

// File: tb/con_xfer_engine_bench.sv
`timescale 1ns/1ps
module con_xfer_engine_bench;
   localparam int DEPTH = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic        sext_mode = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_op = 1'b0;
   logic        rx_in_valid = 1'b0;
   logic [7:0]  rx_in_data = '0;
   logic        irq_en = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        rx_in_ready, irq, tx_valid, mem_req, mem_we, busy, err;
   logic [7:0]  tx_data, mem_wdata, rx_count;
   logic [63:0] mem_addr;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   // reference model state
   logic [63:0] m_ptr = '0, m_addr = '0;
   logic [31:0] m_len = '0, m_rem = '0;
   logic        m_busy = 1'b0, m_rx = 1'b0, m_err = 1'b0, m_txv = 1'b0;
   logic [7:0]  m_txd = '0;
   byte unsigned q[$];

   always #5 clk = ~clk;

   con_xfer_engine u_con_xfer_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .sext_mode(sext_mode), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
      .rx_in_ready(rx_in_ready), .irq_en(irq_en), .irq(irq),
      .tx_valid(tx_valid), .tx_data(tx_data), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .err(err),
      .rx_count(rx_count)
   );

   function automatic logic [7:0] memf(logic [63:0] a);
      return a[7:0] ^ a[39:32] ^ 8'h5A;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // memory responder: random acknowledge delay, data from address
   always @(negedge clk) begin
      mem_ack   <= mem_req && ($urandom_range(0, 2) == 0);
      mem_rdata <= memf(mem_addr);
   end

   // behavioural reference model
   always @(posedge clk) begin
      automatic int sz = q.size();
      if (!rst_n) begin
         m_ptr = '0; m_len = '0; m_busy = 0; m_err = 0; m_txv = 0; q.delete();
      end else begin
         m_txv = 1'b0;
         if (m_busy) begin
            if (mem_ack) begin
               if (m_rx) void'(q.pop_front());
               else begin m_txv = 1'b1; m_txd = memf(m_addr); end
               m_addr = m_addr + 64'd1;
               if (m_rem == 32'd1) m_busy = 1'b0;
               m_rem = m_rem - 32'd1;
            end
         end else if (cmd_valid) begin
            if (m_len == 0) m_err = 1'b0;
            else if (cmd_op && m_len > 32'(sz)) m_err = 1'b1;
            else begin
               m_err = 1'b0; m_busy = 1'b1; m_rx = cmd_op;
               m_addr = m_ptr; m_rem = m_len;
            end
         end
         if (rx_in_valid && sz < DEPTH) q.push_back(rx_in_data);
         if (cfg_we) begin
            case (cfg_sel)
               2'd0: begin
                  m_ptr[31:0] = cfg_wdata;
                  if (sext_mode) m_ptr[63:32] = {32{cfg_wdata[31]}};
               end
               2'd1: m_ptr[63:32] = cfg_wdata;
               2'd2: m_len = cfg_wdata;
               default: ;
            endcase
         end
      end
   end

   // compare every cycle, away from the edge
   always @(posedge clk) begin
      #3;
      if (rst_n) begin
         chk("R6 busy", busy, m_busy);
         chk("R6 R7 mem_req", mem_req, m_busy);
         if (m_busy) begin
            chk("R1 R2 R3 R8 mem_addr", mem_addr, m_addr);
            chk("R4 mem_we", mem_we, m_rx);
            if (m_rx) chk("R4 R8 mem_wdata", mem_wdata, q[0]);
         end
         chk("R3 tx_valid", tx_valid, m_txv);
         if (m_txv) chk("R3 tx_data", tx_data, m_txd);
         chk("R5 err", err, m_err);
         chk("R4 R10 rx_count", rx_count, q.size());
         chk("R10 rx_in_ready", rx_in_ready, q.size() < DEPTH);
         chk("R9 irq", irq, irq_en && q.size() != 0);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 50000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         summary();
         $finish;
      end
   end

   task automatic cfg(logic [1:0] s, logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic issue(logic op);
      cmd_valid = 1'b1; cmd_op = op;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic push(int n);
      for (int i = 0; i < n; i++) begin
         rx_in_valid = 1'b1;
         rx_in_data  = rx_in_data + 8'd1;
         @(negedge clk);
      end
      rx_in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 busy", busy, 0);
      chk("R11 mem_req", mem_req, 0);
      chk("R11 err", err, 0);
      chk("R11 tx_valid", tx_valid, 0);
      chk("R11 rx_count", rx_count, 0);
      chk("R11 rx_in_ready", rx_in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      irq_en = 1'b1;
      push(10);

      // R1: carry across bit 32 during transmit
      cfg(2'd0, 32'hFFFF_FFFE);
      cfg(2'd1, 32'h0000_0002);
      cfg(2'd2, 32'd4);
      issue(1'b0);
      wait_idle();

      // R4: receive three oldest bytes
      cfg(2'd0, 32'h0000_4000);
      cfg(2'd2, 32'd3);
      issue(1'b1);
      wait_idle();
      chk("R4 remaining count", rx_count, 7);

      // R5: over-read by one
      cfg(2'd2, 32'd8);
      issue(1'b1);
      repeat (2) @(negedge clk);
      chk("R5 err set", err, 1);
      chk("R5 count kept", rx_count, 7);

      // R7: zero length clears err, no transfer
      cfg(2'd2, 32'd0);
      issue(1'b0);
      @(negedge clk);
      chk("R7 no busy", busy, 0);
      chk("R7 err cleared", err, 0);

      // R2: sign extension on low-word write
      sext_mode = 1'b1;
      cfg(2'd0, 32'h8000_0010);
      sext_mode = 1'b0;
      cfg(2'd2, 32'd2);
      issue(1'b0);
      wait_idle();

      // R6: second command during a transfer is ignored
      cfg(2'd2, 32'd5);
      issue(1'b0);
      issue(1'b1);
      wait_idle();
      chk("R6 queue untouched", rx_count, 7);

      // R10: fill past capacity
      push(125);
      chk("R10 full", rx_in_ready, 0);
      chk("R10 count at depth", rx_count, DEPTH);

      // R9: drain everything, interrupt falls
      cfg(2'd0, 32'h0000_8000);
      cfg(2'd1, 32'h0);
      cfg(2'd2, 32'd128);
      issue(1'b1);
      wait_idle();
      chk("R9 irq low when empty", irq, 0);
      chk("R4 drained", rx_count, 0);

      irq_en = 1'b0;
      push(2);
      @(negedge clk);
      chk("R9 irq masked", irq, 0);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule